// File: doc/BRIEF.md
# Command/Response Byte FIFO Status Engine

This block runs the byte-stream command and response path of a security-device register interface for whichever locality currently owns it. Software talks to it through two registers: a 32-bit status word and a one-byte data FIFO port. A command goes in one byte at a time. The engine works out the total command length from the command header. While it waits for more bytes it sets an expect flag, and it reports a live burst count of the free space left. A go bit then hands the command to a backend processor over a valid/ready byte stream.

The backend returns the response over a second valid/ready stream that ends with a last flag. The engine stores the response in the same buffer it used for the command and flags it as available. It counts down the remaining response bytes as software drains them through the FIFO port.

The status flags always move through the same sequence: idle, ready, receive, execute, response. Writing the command-ready bit returns the engine to ready from any state except execution.

Top module: `cmdrsp_fifo_engine`

## Requirements
- R1: After reset the status word at offset 0x18 reads 0x0400_8000. Bits 27:26 hold family code 01, bits 23:8 hold the burst count (128 = buffer depth), and the low byte is 0.
- R2: Writing status with bit 6 (command-ready) set makes the low byte read exactly 0x40 and the burst count read 128. This works in idle, ready, receive and response.
- R3: Each byte written to the FIFO at offset 0x24 in ready or receive lowers the burst count by one, down to 0. The low byte reads 0x88 (valid bit 7, expect bit 3) while bytes are still expected, and 0x80 once the final command byte has arrived.
- R4: The command length is header bytes 2..5 read as a big-endian 32-bit value. At least 6 header bytes are always expected.
- R5: A FIFO write while the engine is not expecting bytes (idle, command complete, execution or response) has no effect on status.
- R6: Writing status bit 5 (go) is ignored unless a complete command has been received.
- R7: On go, the stored command bytes go out in order on the backend command stream, one per cycle in which valid and ready are both high. The last flag is set on the final byte.
- R8: Response bytes are collected until the backend marks the last one. Status then reads low byte 0x90 (valid, data-available bit 4) and burst count = response length.
- R9: Each FIFO read in response state returns the next response byte and lowers the burst count by one. The low byte reads 0x80 after the final byte.
- R10: A FIFO read with no response data pending returns 0xFF.
- R11: Command or response bytes beyond the 128-byte buffer are dropped. Only the first 128 bytes are sent or returned.
- R12: Writing command-ready after a response returns the engine to ready with an empty buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational on the offset) |
| cmd_valid_o | output | 1 | Command byte valid to backend |
| cmd_data_o | output | 8 | Command byte |
| cmd_last_o | output | 1 | Final command byte |
| cmd_ready_i | input | 1 | Backend accepts command byte |
| rsp_valid_i | input | 1 | Response byte valid from backend |
| rsp_data_i | input | 8 | Response byte |
| rsp_last_i | input | 1 | Final response byte |
| rsp_ready_o | output | 1 | Engine accepts response byte |

## Verification
The assertions check several properties on every cycle:
- the burst count never exceeds the buffer depth;
- expect and data-available are never set together;
- the response read pointer never passes the response length;
- go from an incomplete command never reaches execution;
- the tracker never counts a byte once the command is complete;
- an accepted non-final command byte is followed by another valid byte;
- a command-ready write always lands in an empty ready state.

Other behaviour needs the bench scenarios, which drive complete transactions. These show the exact burst-count and flag sequences, the big-endian parsing of the length, and the byte-for-byte contents on both backend streams. They also show truncation at the buffer limit and the 0xFF read value.

// File: rtl/cre_pkg.sv
package cre_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READY, ST_RECV, ST_SEND, ST_COLLECT, ST_RESP
  } eng_state_e;

  localparam logic [11:0] OFS_STATUS = 12'h018;
  localparam logic [11:0] OFS_FIFO   = 12'h024;

  localparam int BIT_VALID  = 7;
  localparam int BIT_CMDRDY = 6;
  localparam int BIT_GO     = 5;
  localparam int BIT_AVAIL  = 4;
  localparam int BIT_EXPECT = 3;

  localparam logic [1:0] FAMILY_CODE = 2'b01;
  localparam int HDR_MIN = 6;
endpackage

// File: rtl/cmd_len_tracker.sv
module cmd_len_tracker
  import cre_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic [7:0]       byte_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             need_more_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
      len_q <= '0;
    end else if (push_i) begin
      cnt_q <= cnt_q + 1'b1;
      // header bytes 2..5 form the big-endian length
      if (cnt_q >= CNT_W'(2) && cnt_q <= CNT_W'(5)) len_q <= {len_q[23:0], byte_i};
    end
  end

  assign cnt_o       = cnt_q;
  assign need_more_o = (cnt_q < CNT_W'(HDR_MIN)) || (64'(cnt_q) < 64'(len_q));

  p_push_needs_more_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> need_more_o);
endmodule

// File: rtl/xfer_buf.sv
module xfer_buf #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

  p_waddr_in_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (32'(waddr_i) < DEPTH));
endmodule

// File: rtl/cmdrsp_fifo_engine.sv
module cmdrsp_fifo_engine
  import cre_pkg::*;
#(
  parameter int BUF_DEPTH = 128,
  parameter int ADDR_W    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              cmd_valid_o,
  output logic [7:0]        cmd_data_o,
  output logic              cmd_last_o,
  input  logic              cmd_ready_i,
  input  logic              rsp_valid_i,
  input  logic [7:0]        rsp_data_i,
  input  logic              rsp_last_i,
  output logic              rsp_ready_o
);
  localparam int AW    = $clog2(BUF_DEPTH);
  localparam int PTR_W = $clog2(BUF_DEPTH + 1);
  localparam int CNT_W = 32;

  eng_state_e       state_q;
  logic [PTR_W-1:0] fill_q, xfer_q, rsp_len_q, rd_q;
  logic [CNT_W-1:0] rcv_cnt;
  logic             need_more;
  logic [7:0]       buf_rdata;
  logic [7:0]       low_byte;
  logic [15:0]      burst;

  logic wr_sts, wr_fifo, rd_fifo, executing;
  logic cmd_rdy_req, go_req, push, store, avail, pop;
  logic send_fire, rsp_fire, rsp_store;

  assign wr_sts  = bus_en_i && bus_we_i && bus_addr_i == ADDR_W'(OFS_STATUS);
  assign wr_fifo = bus_en_i && bus_we_i && bus_addr_i == ADDR_W'(OFS_FIFO);
  assign rd_fifo = bus_en_i && !bus_we_i && bus_addr_i == ADDR_W'(OFS_FIFO);

  assign executing   = state_q == ST_SEND || state_q == ST_COLLECT;
  assign cmd_rdy_req = wr_sts && bus_wdata_i[BIT_CMDRDY] && !executing;
  assign go_req      = wr_sts && bus_wdata_i[BIT_GO] && !bus_wdata_i[BIT_CMDRDY]
                       && state_q == ST_RECV && !need_more;
  assign push        = wr_fifo && (state_q == ST_READY || state_q == ST_RECV) && need_more;
  assign store       = push && fill_q < PTR_W'(BUF_DEPTH);
  assign avail       = state_q == ST_RESP && rd_q < rsp_len_q;
  assign pop         = rd_fifo && avail;

  assign cmd_valid_o = state_q == ST_SEND;
  assign cmd_last_o  = cmd_valid_o && xfer_q == fill_q - 1'b1;
  assign cmd_data_o  = buf_rdata;
  assign send_fire   = cmd_valid_o && cmd_ready_i;
  assign rsp_ready_o = state_q == ST_COLLECT;
  assign rsp_fire    = rsp_valid_i && rsp_ready_o;
  assign rsp_store   = rsp_fire && xfer_q < PTR_W'(BUF_DEPTH);

  cmd_len_tracker #(.CNT_W(CNT_W)) u_len (
    .clk_i, .rst_ni,
    .clear_i    (cmd_rdy_req),
    .push_i     (push),
    .byte_i     (bus_wdata_i[7:0]),
    .cnt_o      (rcv_cnt),
    .need_more_o(need_more)
  );

  xfer_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk_i, .rst_ni,
    .we_i   (store || rsp_store),
    .waddr_i(store ? fill_q[AW-1:0] : xfer_q[AW-1:0]),
    .wdata_i(store ? bus_wdata_i[7:0] : rsp_data_i),
    .raddr_i(state_q == ST_SEND ? xfer_q[AW-1:0] : rd_q[AW-1:0]),
    .rdata_o(buf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      fill_q    <= '0;
      xfer_q    <= '0;
      rsp_len_q <= '0;
      rd_q      <= '0;
    end else begin
      if (store) fill_q <= fill_q + 1'b1;
      unique case (state_q)
        ST_IDLE, ST_READY, ST_RECV, ST_RESP: begin
          if (cmd_rdy_req) begin
            state_q <= ST_READY;
            fill_q  <= '0;
            rd_q    <= '0;
          end else if (go_req) begin
            state_q <= ST_SEND;
            xfer_q  <= '0;
          end else if (push) begin
            state_q <= ST_RECV;
          end else if (pop) begin
            rd_q <= rd_q + 1'b1;
          end
        end
        ST_SEND: if (send_fire) begin
          if (cmd_last_o) begin
            state_q <= ST_COLLECT;
            xfer_q  <= '0;
          end else begin
            xfer_q <= xfer_q + 1'b1;
          end
        end
        ST_COLLECT: if (rsp_fire) begin
          if (rsp_store) xfer_q <= xfer_q + 1'b1;
          if (rsp_last_i) begin
            state_q   <= ST_RESP;
            rsp_len_q <= xfer_q + PTR_W'(rsp_store);
            rd_q      <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    low_byte = 8'h00;
    burst    = 16'h0;
    unique case (state_q)
      ST_IDLE:  burst = 16'(BUF_DEPTH);
      ST_READY: begin
        low_byte[BIT_CMDRDY] = 1'b1;
        burst = 16'(BUF_DEPTH);
      end
      ST_RECV: begin
        low_byte[BIT_VALID]  = 1'b1;
        low_byte[BIT_EXPECT] = need_more;
        burst = 16'(BUF_DEPTH) - 16'(fill_q);
      end
      ST_SEND, ST_COLLECT: low_byte[BIT_VALID] = 1'b1;
      ST_RESP: begin
        low_byte[BIT_VALID] = 1'b1;
        low_byte[BIT_AVAIL] = avail;
        burst = 16'(rsp_len_q) - 16'(rd_q);
      end
      default: ;
    endcase
  end

  always_comb begin
    bus_rdata_o = 32'h0;
    if (bus_addr_i == ADDR_W'(OFS_STATUS))
      bus_rdata_o = {4'h0, FAMILY_CODE, 2'b00, burst, low_byte};
    else if (bus_addr_i == ADDR_W'(OFS_FIFO))
      bus_rdata_o = {24'h0, avail ? buf_rdata : 8'hFF};
  end

  logic unused_ok;
  assign unused_ok = ^{bus_wdata_i[31:8], rcv_cnt};

  p_burst_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(burst) <= BUF_DEPTH);
  p_expect_avail_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(low_byte[BIT_EXPECT] && low_byte[BIT_AVAIL]));
  p_go_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RECV && need_more) |=> state_q != ST_SEND);
  p_send_stream_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_fire && !cmd_last_o) |=> cmd_valid_o);
  p_rd_ptr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RESP |-> rd_q <= rsp_len_q);
  p_ready_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rdy_req |=> (state_q == ST_READY && fill_q == '0));
endmodule

// File: tb/sim_cmdrsp_fifo_engine.sv
`timescale 1ns/1ps
module sim_cmdrsp_fifo_engine;
  localparam logic [11:0] STS  = 12'h018;
  localparam logic [11:0] FIFO = 12'h024;
  localparam int DEPTH = 128;
  // {command bytes written, length field, response bytes}
  localparam int VEC [4][3] = '{'{12, 12, 10}, '{6, 6, 1}, '{10, 10, 130}, '{6, 3, 4}};

  logic clk = 0, rst_n = 0;
  logic en = 0, we = 0;
  logic [11:0] addr = STS;
  logic [31:0] wdata = 0, rdata;
  logic cmd_valid, cmd_last, rsp_ready;
  logic [7:0] cmd_data;
  logic rsp_valid = 0, rsp_last = 0;
  logic [7:0] rsp_data = 0;
  int n_chk = 0, n_fail = 0;
  int cap_n = 0, last_idx = -1;
  logic [7:0] cap [512];
  bit done = 0;

  always #5 clk = ~clk;

  cmdrsp_fifo_engine u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_en_i(en), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .cmd_valid_o(cmd_valid), .cmd_data_o(cmd_data), .cmd_last_o(cmd_last), .cmd_ready_i(1'b1),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data), .rsp_last_i(rsp_last), .rsp_ready_o(rsp_ready)
  );

  always @(posedge clk) begin
    if (cmd_valid) begin
      cap[cap_n] = cmd_data;
      if (cmd_last) last_idx = cap_n;
      cap_n = cap_n + 1;
    end
  end

  function automatic logic [31:0] sts_word(int b, logic [7:0] lo);
    return {4'h0, 2'b01, 2'b00, 16'(b), lo};
  endfunction
  function automatic logic [7:0] cmd_byte(int i, int lenf);
    if (i == 0) return 8'h80;
    if (i == 1) return 8'h01;
    if (i <= 5) return 8'((lenf >> (8 * (5 - i))) & 255);
    return 8'((i * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] rsp_byte(int i);
    return 8'((i * 13 + 5) & 255);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); en = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); en = 0; we = 0;
  endtask
  task automatic sts_rd(output logic [31:0] v);
    @(negedge clk); en = 0; addr = STS; #1 v = rdata;
  endtask
  task automatic fifo_rd(output logic [7:0] b);
    @(negedge clk); en = 1; we = 0; addr = FIFO; #1 b = rdata[7:0];
    @(negedge clk); en = 0;
  endtask
  task automatic drive_rsp(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rsp_valid = 1; rsp_data = rsp_byte(i); rsp_last = (i == n - 1);
      #1;
      while (!rsp_ready) begin @(negedge clk); #1; end
    end
    @(negedge clk); rsp_valid = 0; rsp_last = 0;
  endtask

  task automatic run_txn(input int nb, input int lenf, input int nr);
    logic [31:0] v;
    logic [7:0] b;
    int need, nsend, ncap, mism;
    need = lenf < 6 ? 6 : lenf;
    bus_wr(STS, 32'h40); sts_rd(v); chk("R2 ready", v, sts_word(DEPTH, 8'h40));
    for (int i = 0; i < nb; i++) begin
      bus_wr(FIFO, {24'h0, cmd_byte(i, lenf)}); sts_rd(v);
      chk(i + 1 > DEPTH ? "R11 cmd overflow" : "R3 R4 cmd byte", v,
          sts_word(DEPTH - (i + 1 > DEPTH ? DEPTH : i + 1), (i + 1 < need) ? 8'h88 : 8'h80));
    end
    cap_n = 0; last_idx = -1;
    bus_wr(STS, 32'h20);
    drive_rsp(nr);
    nsend = nb > DEPTH ? DEPTH : nb;
    chk(nb > DEPTH ? "R11 send count" : "R7 send count", cap_n, nsend);
    chk("R7 last flag", last_idx, nsend - 1);
    mism = 0;
    for (int i = 0; i < nsend; i++) if (cap[i] !== cmd_byte(i, lenf)) mism++;
    chk("R7 send data", mism, 0);
    ncap = nr > DEPTH ? DEPTH : nr;
    sts_rd(v); chk(nr > DEPTH ? "R11 rsp capped" : "R8 rsp avail", v, sts_word(ncap, 8'h90));
    for (int i = 0; i < ncap; i++) begin
      fifo_rd(b); chk("R9 rsp data", b, rsp_byte(i));
      sts_rd(v); chk("R9 rsp status", v, sts_word(ncap - i - 1, (i + 1 < ncap) ? 8'h90 : 8'h80));
    end
    fifo_rd(b); chk("R10 drained read", b, 8'hFF);
    bus_wr(STS, 32'h40); sts_rd(v); chk("R12 back to ready", v, sts_word(DEPTH, 8'h40));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    sts_rd(v); chk("R1 reset status", v, 32'h0400_8000);
    fifo_rd(b); chk("R10 idle read", b, 8'hFF);
    bus_wr(FIFO, 32'h11); sts_rd(v); chk("R5 idle write ignored", v, 32'h0400_8000);
    bus_wr(STS, 32'h20); sts_rd(v); chk("R6 idle go ignored", v, 32'h0400_8000);

    foreach (VEC[k]) run_txn(VEC[k][0], VEC[k][1], VEC[k][2]);

    // partial command: go must be ignored
    bus_wr(STS, 32'h40);
    for (int i = 0; i < 4; i++) bus_wr(FIFO, {24'h0, cmd_byte(i, 8)});
    bus_wr(STS, 32'h20); sts_rd(v); chk("R6 go on partial", v, sts_word(124, 8'h88));
    for (int i = 4; i < 8; i++) bus_wr(FIFO, {24'h0, cmd_byte(i, 8)});
    sts_rd(v); chk("R4 len 8 complete", v, sts_word(120, 8'h80));
    bus_wr(FIFO, 32'hAA); sts_rd(v); chk("R5 extra byte ignored", v, sts_word(120, 8'h80));
    bus_wr(STS, 32'h40); sts_rd(v); chk("R2 abort to ready", v, sts_word(DEPTH, 8'h40));

    // big-endian 256-byte command: overflow past the buffer
    run_txn(256, 256, 3);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule